// File: doc/BRIEF.md
# Disk DMA Channel Status Register

This block is the 8-bit status register for one channel of a bus-master disk DMA controller. Software reads and writes it through a simple single-cycle register port. It records three kinds of hardware events. The first is a new interrupt request from the attached drive, detected on a rising edge. The second is an aborted transfer on the system bus. The third is the active state of the DMA command, which follows the command start bit and the end-of-table completion from the descriptor engine.

Two bits are owned entirely by software. They record whether each of the two drives on the channel can perform DMA, and they influence nothing else in the block. The two event bits are cleared by writing a one to them. When an event arrives in the same cycle as a clear, the event wins, so a completion is never lost. The active bit is read-only.

The descriptor engine, the bus master and the command register are outside this block. Their events arrive as pulses or levels. The asynchronous active-low reset is released through a local synchronizer, and every register clears to 00h.

Top module: `dma_chan_status`

## Requirements
- R1: While in reset, and in the first cycles after reset is released, `reg_rdata` reads 8'h00.
- R2: Bits 7, 4 and 3 of `reg_rdata` always read 0, whatever value is written.
- R3: Bits 6 (drive 1 capable) and 5 (drive 0 capable) take bits 6 and 5 of `reg_wdata` on every write, hold their value otherwise, and change no other bit.
- R4: Bit 2 (interrupt seen) reads 1 in the cycle after `dev_irq` is first sampled high following a low sample. A level that stays high without a new low-to-high transition never sets it.
- R5: A write with bit 2 at 1 clears bit 2, and a write with bit 2 at 0 leaves it unchanged.
- R6: If bit 2 is cleared while `dev_irq` stays high, bit 2 stays 0 until `dev_irq` goes low and then high again.
- R7: A one-cycle `bus_abort` pulse sets bit 1 (transfer error) in the next cycle. A write with bit 1 at 1 clears it, and a write with bit 1 at 0 leaves it unchanged.
- R8: Bit 0 (command active) reads 1 in the cycle after `cmd_start` is first sampled high following a low sample. Writes never change bit 0.
- R9: Bit 0 clears in the cycle after an `eot_done` pulse, or in the cycle after `cmd_start` is first sampled low following a high sample.
- R10: Setting bit 2 never clears bit 0, so bits 2 and 0 can both read 1.
- R11: When a set event for bit 2 or bit 1 falls in the same cycle as a write-one clear of that bit, the bit reads 1 afterwards.
- R12: When a rising edge of `cmd_start` falls in the same cycle as an `eot_done` pulse, bit 0 reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | One-cycle register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current register value, with no read side effects |
| dev_irq | input | 1 | Interrupt request level from the drive |
| bus_abort | input | 1 | One-cycle pulse reporting a target or master abort |
| cmd_start | input | 1 | Start bit level from the command register |
| eot_done | input | 1 | One-cycle pulse when the last transfer of the end-of-table region completes |

## Verification
A write-one clear of an event bit can arrive in the same cycle as a new event for that bit. In the same way, an end-of-table pulse can meet a fresh command start. The bench drives all sixteen combinations of interrupt edge, abort pulse and the two clear bits on one clock edge. It does this once from a fully clear state and once from a state where both event bits are set, and it checks each resulting bit against set-or-hold arithmetic. It then starts a command exactly on an end-of-table pulse and expects the active bit to survive.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_ACT   = 0;
  localparam int BIT_ERR   = 1;
  localparam int BIT_IRQ   = 2;
  localparam int BIT_CAP0  = 5;
  localparam int BIT_CAP1  = 6;
  localparam int NUM_EVT   = 2;
  localparam int NUM_CAP   = 2;
  localparam int NUM_LVL   = 2;
  localparam int LVL_IRQ   = 0;
  localparam int LVL_START = 1;

  // event slot -> register bit position
  function automatic int evt_pos(input int idx);
    return (idx == 0) ? BIT_ERR : BIT_IRQ;
  endfunction

  function automatic int cap_pos(input int idx);
    return (idx == 0) ? BIT_CAP0 : BIT_CAP1;
  endfunction
endpackage

// File: rtl/dsr_rst_sync.sv
module dsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dsr_edge_det.sv
module dsr_edge_det #(
  parameter logic HIST_RST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic rise,
  output logic fall
);
  logic hist_q;
  logic hist_d;

  always_comb begin
    hist_d = lvl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= HIST_RST;
    else        hist_q <= hist_d;
  end

  assign rise = lvl_in & ~hist_q;
  assign fall = ~lvl_in & hist_q;
endmodule

// File: rtl/dsr_w1c_bit.sv
module dsr_w1c_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_wr,
  output logic q
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_evt | clr_wr;
    // a set in the same cycle as a clear wins
    q_d  = set_evt ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/dsr_active_trk.sv
module dsr_active_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic start_rise,
  input  logic start_fall,
  input  logic eot_done,
  output logic active
);
  logic act_d;
  logic act_en;

  always_comb begin
    act_en = start_rise | start_fall | eot_done;
    if (start_rise) act_d = 1'b1;
    else            act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      active <= 1'b0;
    else if (act_en) active <= act_d;
  end
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             dev_irq,
  input  logic             bus_abort,
  input  logic             cmd_start,
  input  logic             eot_done
);
  logic               rst_sync_n;
  logic [NUM_LVL-1:0] lvl_in;
  logic [NUM_LVL-1:0] lvl_rise;
  logic [NUM_LVL-1:0] lvl_fall;
  logic [NUM_EVT-1:0] evt_set;
  logic [NUM_EVT-1:0] evt_clr;
  logic [NUM_EVT-1:0] evt_q;
  logic [NUM_CAP-1:0] cap_q;
  logic [NUM_CAP-1:0] cap_d;
  logic               cap_en;
  logic               act_q;
  logic               unused_sig;

  dsr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign lvl_in[LVL_IRQ]   = dev_irq;
  assign lvl_in[LVL_START] = cmd_start;

  generate
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_edge
      dsr_edge_det #(.HIST_RST(1'b1)) u_edge (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .lvl_in (lvl_in[g]),
        .rise   (lvl_rise[g]),
        .fall   (lvl_fall[g])
      );
    end
  endgenerate

  assign evt_set[0] = bus_abort;
  assign evt_set[1] = lvl_rise[LVL_IRQ];

  generate
    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      assign evt_clr[e] = reg_wr_en & reg_wdata[evt_pos(e)];
      dsr_w1c_bit u_bit (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .set_evt (evt_set[e]),
        .clr_wr  (evt_clr[e]),
        .q       (evt_q[e])
      );
    end
  endgenerate

  always_comb begin
    cap_en = reg_wr_en;
    for (int c = 0; c < NUM_CAP; c++) cap_d[c] = reg_wdata[cap_pos(c)];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cap_q <= '0;
    else if (cap_en)  cap_q <= cap_d;
  end

  dsr_active_trk u_act (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_rise (lvl_rise[LVL_START]),
    .start_fall (lvl_fall[LVL_START]),
    .eot_done   (eot_done),
    .active     (act_q)
  );

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[BIT_ACT] = act_q;
    for (int e = 0; e < NUM_EVT; e++) reg_rdata[evt_pos(e)] = evt_q[e];
    for (int c = 0; c < NUM_CAP; c++) reg_rdata[cap_pos(c)] = cap_q[c];
  end

  assign unused_sig = ^{reg_wdata[7], reg_wdata[4:3], reg_wdata[0], lvl_fall[LVL_IRQ]};
endmodule

// File: rtl/dma_chan_status_chk.sv
module dma_chan_status_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       reg_wr_en,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       dev_irq,
  input logic       bus_abort,
  input logic       cmd_start,
  input logic       eot_done
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_rdata[7] == 1'b0) && (reg_rdata[4:3] == 2'b00)); // R2

  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_ok)
    reg_wr_en |=> reg_rdata[6:5] == $past(reg_wdata[6:5])); // R3

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !reg_wr_en |=> $stable(reg_rdata[6:5])); // R3

  AST_IRQ_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(dev_irq) |=> reg_rdata[2]); // R4

  AST_IRQ_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rst_ok)
    (dev_irq && $past(dev_irq) && !reg_rdata[2]) |=> !reg_rdata[2]); // R6

  AST_IRQ_W1C: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_wr_en && reg_wdata[2] && !$rose(dev_irq)) |=> !reg_rdata[2]); // R5

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    bus_abort |=> reg_rdata[1]); // R7

  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_abort && reg_wr_en && reg_wdata[1]) |=> reg_rdata[1]); // R11

  AST_ACT_START: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(cmd_start) |=> reg_rdata[0]); // R8

  AST_ACT_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_ok)
    (!reg_rdata[0] && !$rose(cmd_start)) |=> !reg_rdata[0]); // R8

  AST_ACT_EOT_CLR: assert property (@(posedge clk) disable iff (!rst_ok)
    (eot_done && !$rose(cmd_start)) |=> !reg_rdata[0]); // R9

  AST_ACT_KEEP: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_rdata[0] && !eot_done && !$fell(cmd_start)) |=> reg_rdata[0]); // R10
endmodule

bind dma_chan_status dma_chan_status_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .reg_wr_en (reg_wr_en),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .dev_irq   (dev_irq),
  .bus_abort (bus_abort),
  .cmd_start (cmd_start),
  .eot_done  (eot_done)
);

// File: tb/dma_chan_status_tb.sv
module dma_chan_status_tb;
  logic       clk;
  logic       rst_n;
  logic       reg_wr_en;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       dev_irq;
  logic       bus_abort;
  logic       cmd_start;
  logic       eot_done;

  int n_run;
  int n_fail;
  logic [7:0] caps;

  dma_chan_status u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dev_irq   (dev_irq),
    .bus_abort (bus_abort),
    .cmd_start (cmd_start),
    .eot_done  (eot_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  // write one value; inputs return to idle afterwards
  task automatic wr(input logic [7:0] v);
    reg_wr_en = 1'b1;
    reg_wdata = v;
    step();
    reg_wr_en = 1'b0;
    reg_wdata = 8'h00;
  endtask

  task automatic irq_pulse();
    dev_irq = 1'b1;
    step();
    dev_irq = 1'b0;
    step();
  endtask

  task automatic abort_pulse();
    bus_abort = 1'b1;
    step();
    bus_abort = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0; caps = 8'h00;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wdata = 8'h00;
    dev_irq = 1'b0; bus_abort = 1'b0; cmd_start = 1'b0; eot_done = 1'b0;
    step(); step();
    chk("R1 in reset", reg_rdata, 8'h00);
    rst_n = 1'b1;
    step();
    chk("R1 after release", reg_rdata, 8'h00);
    step(); step(); step();
    chk("R1 settled", reg_rdata, 8'h00);

    // R2/R3/R5/R7/R8: every write value with both event bits armed
    for (int v = 0; v < 256; v++) begin
      irq_pulse();
      abort_pulse();
      chk("R4 R7 armed", reg_rdata, caps | 8'h06);
      wr(v[7:0]);
      caps = v[7:0] & 8'h60;
      chk("R2 R3 R5 R7 R8 write sweep", reg_rdata,
          caps | (~v[7:0] & 8'h06));
    end

    // R4/R6: level does not set, clear while high stays clear
    wr(caps | 8'h06);
    dev_irq = 1'b1;
    step();
    chk("R4 edge sets", reg_rdata, caps | 8'h04);
    wr(caps | 8'h04);
    chk("R5 clear while high", reg_rdata, caps);
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R6 held level stays clear", reg_rdata, caps);
    end
    dev_irq = 1'b0;
    step();
    chk("R6 low", reg_rdata, caps);
    dev_irq = 1'b1;
    step();
    chk("R6 new edge sets", reg_rdata, caps | 8'h04);
    wr(caps);
    chk("R5 write zero keeps", reg_rdata, caps | 8'h04);
    dev_irq = 1'b0;
    wr(caps | 8'h04);
    chk("R5 cleared", reg_rdata, caps);

    // R8/R9/R10 active bit
    cmd_start = 1'b1;
    step();
    chk("R8 start sets", reg_rdata, caps | 8'h01);
    wr(caps | 8'h00);
    chk("R8 write ignored", reg_rdata, caps | 8'h01);
    irq_pulse();
    chk("R10 irq keeps active", reg_rdata, caps | 8'h05);
    eot_done = 1'b1;
    step();
    eot_done = 1'b0;
    chk("R9 eot clears", reg_rdata, caps | 8'h04);
    step(); step();
    chk("R8 level does not re-set", reg_rdata, caps | 8'h04);
    cmd_start = 1'b0;
    step();
    cmd_start = 1'b1;
    step();
    chk("R8 second start", reg_rdata, caps | 8'h05);
    cmd_start = 1'b0;
    step();
    chk("R9 start fall clears", reg_rdata, caps | 8'h04);
    cmd_start = 1'b1;
    eot_done = 1'b1;
    step();
    eot_done = 1'b0;
    chk("R12 start beats eot", reg_rdata, caps | 8'h05);
    cmd_start = 1'b0;
    step();
    chk("R9 stop", reg_rdata, caps | 8'h04);

    // R11: same-cycle set and clear, all combinations
    for (int init = 0; init < 2; init++) begin
      for (int c = 0; c < 16; c++) begin
        logic e2;
        logic e1;
        wr(caps | 8'h06);
        if (init == 1) begin
          irq_pulse();
          abort_pulse();
        end
        dev_irq   = c[0];
        bus_abort = c[1];
        reg_wr_en = 1'b1;
        reg_wdata = caps | {5'b0, c[2], c[3], 1'b0};
        step();
        reg_wr_en = 1'b0;
        reg_wdata = 8'h00;
        bus_abort = 1'b0;
        e2 = c[0] | ((init == 1) & ~c[2]);
        e1 = c[1] | ((init == 1) & ~c[3]);
        chk("R11 set vs clear", reg_rdata, caps | {5'b0, e2, e1, 1'b0});
        dev_irq = 1'b0;
        step();
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule